// File: doc/BRIEF.md
# Embedded Single-Precision Add/Subtract Unit

This unit adds or subtracts two 32-bit single-precision words and returns a 32-bit result with five status flags one clock later. It follows an embedded-vector arithmetic policy. Inputs that encode infinity, NaN or a denormal are reported as invalid, but they are still computed as finite values. The result is always an ordinary finite number or a signed zero, never an infinity, a NaN or a denormal.

Subtraction inverts the sign of the second operand and then adds. Both significands are aligned, keeping a guard bit, a round bit and a sticky bit. After the sum is normalised it is truncated toward zero. Results that are too small are flushed to a signed zero. Results that are too large are clamped to the largest finite magnitude. The discarded bits drive a guard flag and an inexact flag, which only report when nothing more serious was flagged.

A result word is captured whenever `in_valid` is high and is then held until the next accepted operation.

Top module: `fpa_addsub`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high after that edge with the result of that operation. When `in_valid` is low, `out_valid` is low after the edge. Reset clears `out_valid`, `result` and all flags to 0.
- R2: When `op_sub` is 1, the result equals `opa` plus `opb` with bit 31 (the sign) of `opb` inverted. When `op_sub` is 0, the two operands are added.
- R3: A nonzero result is the exact sum truncated toward zero to a 24-bit significand. Its sign is that of the operand with the larger magnitude. The layout is sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0.
- R4: An input with exponent field 255 is treated as the value 1.fraction with biased exponent 255 (unbiased 128). An input with exponent field 0 and a nonzero fraction is treated as 0.fraction with biased exponent 1. Either kind, in either operand or both, sets the single `flag_invalid` bit.
- R5: If the normalised biased exponent is 0 or below, the result is a zero carrying the computed sign. `flag_underflow` is set only if `flag_invalid` is clear.
- R6: If the normalised biased exponent is 254 or above, the result is the computed sign followed by 0x7F7FFFFF (exponent 0xFE, all-ones fraction). `flag_overflow` is set only if `flag_invalid` is clear.
- R7: An exactly zero sum is returned as a zero with the sign of `opa`, and it raises neither underflow nor guard nor inexact.
- R8: For an in-range result, `flag_guard` is the first bit below the kept significand. `flag_inexact` is the OR of all bits below that one.
- R9: `flag_guard` and `flag_inexact` are 0 whenever `flag_invalid`, `flag_overflow` or `flag_underflow` is set.
- R10: While `in_valid` is low, `result` and every flag keep their values regardless of the operand inputs.
- R11: The result never has exponent field 255, and never has exponent field 0 with a nonzero fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and select are accepted at this edge |
| op_sub | input | 1 | 1 selects opa minus opb, 0 selects opa plus opb |
| opa | input | 32 | First operand, single-precision word |
| opb | input | 32 | Second operand, single-precision word |
| out_valid | output | 1 | Result of the previous cycle's accepted operation is present |
| result | output | 32 | Sum or difference |
| flag_invalid | output | 1 | An operand was infinity, NaN or denormal |
| flag_overflow | output | 1 | Result clamped to maximum magnitude |
| flag_underflow | output | 1 | Result flushed to zero |
| flag_guard | output | 1 | First discarded bit |
| flag_inexact | output | 1 | Some lower discarded bit was nonzero |

## Verification
The hardest situations to reach from the ports are the ones where the flag priority matters. Examples are a special operand whose sum also lands beyond the clamp threshold, or a denormal operand that would otherwise leave guard bits, where the lower flags must stay silent. Directed pairs reach these: infinity plus one, infinity minus infinity, a denormal plus one, and two denormals whose sum renormalises into the smallest normal exponent. Near-cancelling subtractions around the smallest normal exponent reach the flush boundary. Random operands with nearby exponents exercise long normalisation shifts. Each result is compared against a bench model that sums exact wide integers.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    // Status flags produced with every result
    typedef struct packed {
        logic inv;
        logic ovf;
        logic unf;
        logic grd;
        logic inx;
    } fpa_flags_t;

    // Number of extra low bits carried through alignment: guard, round, sticky
    localparam int GRS_W = 3;

endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    input  logic                  flip,
    output logic                  sign,
    output logic [EXP_W-1:0]      expo,
    output logic [FRAC_W:0]       man,
    output logic                  odd
);

    logic [EXP_W-1:0]  ef;
    logic [FRAC_W-1:0] fr;
    logic              e_ones;
    logic              e_zero;
    logic              f_nz;

    always_comb begin
        ef     = word[EXP_W+FRAC_W-1:FRAC_W];
        fr     = word[FRAC_W-1:0];
        e_ones = &ef;
        e_zero = ~|ef;
        f_nz   = |fr;
        sign   = word[EXP_W+FRAC_W] ^ flip;
        if (e_ones) begin
            // infinity or NaN: keep the top exponent, hidden one present
            expo = ef;
            man  = {1'b1, fr};
            odd  = 1'b1;
        end else if (e_zero) begin
            // zero or denormal: true value at exponent one, no hidden one
            expo = f_nz ? {{(EXP_W-1){1'b0}}, 1'b1} : '0;
            man  = {1'b0, fr};
            odd  = f_nz;
        end else begin
            expo = ef;
            man  = {1'b1, fr};
            odd  = 1'b0;
        end
    end

endmodule

// File: rtl/fpa_align_add.sv
module fpa_align_add #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 24
) (
    input  logic                 sa,
    input  logic [EXP_W-1:0]     ea,
    input  logic [MAN_W-1:0]     ma,
    input  logic                 sb,
    input  logic [EXP_W-1:0]     eb,
    input  logic [MAN_W-1:0]     mb,
    output logic [MAN_W+3:0]     sum,
    output logic [EXP_W-1:0]     e_big,
    output logic                 s_big
);

    localparam int EXT_W = MAN_W + fpa_pkg::GRS_W;
    localparam int SH_W  = MAN_W + EXT_W;
    localparam int SUM_W = EXT_W + 1;

    logic              a_ge;
    logic [EXP_W-1:0]  e_small;
    logic [MAN_W-1:0]  m_big;
    logic [MAN_W-1:0]  m_small;
    logic              s_small;
    logic [EXP_W-1:0]  diff;
    logic              far;
    logic [SH_W-1:0]   wide;
    logic [EXT_W-1:0]  aligned;
    logic [SUM_W-1:0]  big_ext;
    logic [SUM_W-1:0]  small_ext;

    always_comb begin
        // larger magnitude first; ties keep operand a on top
        a_ge    = {ea, ma} >= {eb, mb};
        e_big   = a_ge ? ea : eb;
        e_small = a_ge ? eb : ea;
        m_big   = a_ge ? ma : mb;
        m_small = a_ge ? mb : ma;
        s_big   = a_ge ? sa : sb;
        s_small = a_ge ? sb : sa;

        diff = e_big - e_small;
        far  = 32'(diff) >= 32'(EXT_W);
        wide = {m_small, {EXT_W{1'b0}}} >> diff;
        if (far) begin
            aligned = {{(EXT_W-1){1'b0}}, |m_small};
        end else begin
            aligned = {wide[SH_W-1 -: EXT_W-1], |wide[SH_W-EXT_W:0]};
        end

        big_ext   = {1'b0, m_big, {fpa_pkg::GRS_W{1'b0}}};
        small_ext = {1'b0, aligned};
        if (s_big ^ s_small) begin
            sum = big_ext - small_ext;
        end else begin
            sum = big_ext + small_ext;
        end
    end

endmodule

// File: rtl/fpa_normalize.sv
module fpa_normalize #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 24
) (
    input  logic [MAN_W+3:0]         sum,
    input  logic [EXP_W-1:0]         e_big,
    output logic [MAN_W-1:0]         man,
    output logic signed [EXP_W+1:0]  exp_s,
    output logic                     grd,
    output logic                     inx,
    output logic                     zero
);

    localparam int LOW_W = MAN_W + fpa_pkg::GRS_W;
    localparam int SUM_W = LOW_W + 1;
    localparam int LZ_W  = $clog2(LOW_W + 1);
    localparam int ES_W  = EXP_W + 2;

    logic [LZ_W-1:0]        lz;
    logic                   found;
    logic [LOW_W-1:0]       norm;
    logic signed [ES_W-1:0] eb_s;
    logic signed [ES_W-1:0] lz_s;

    always_comb begin
        lz    = LZ_W'(LOW_W);
        found = 1'b0;
        for (int i = LOW_W - 1; i >= 0; i--) begin
            if (!found && sum[i]) begin
                lz    = LZ_W'(LOW_W - 1 - i);
                found = 1'b1;
            end
        end
        norm = sum[LOW_W-1:0] << lz;
        eb_s = $signed({2'b00, e_big});
        lz_s = $signed({{(ES_W-LZ_W){1'b0}}, lz});
        zero = ~|sum;

        if (sum[SUM_W-1]) begin
            // carry out: one place right
            man   = sum[SUM_W-1 -: MAN_W];
            grd   = sum[fpa_pkg::GRS_W];
            inx   = |sum[fpa_pkg::GRS_W-1:0];
            exp_s = eb_s + ES_W'(1);
        end else begin
            man   = norm[LOW_W-1 -: MAN_W];
            grd   = norm[fpa_pkg::GRS_W-1];
            inx   = |norm[fpa_pkg::GRS_W-2:0];
            exp_s = eb_s - lz_s;
        end
    end

endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    op_sub,
    input  logic [EXP_W+FRAC_W:0]   opa,
    input  logic [EXP_W+FRAC_W:0]   opb,
    output logic                    out_valid,
    output logic [EXP_W+FRAC_W:0]   result,
    output logic                    flag_invalid,
    output logic                    flag_overflow,
    output logic                    flag_underflow,
    output logic                    flag_guard,
    output logic                    flag_inexact
);

    localparam int W     = EXP_W + FRAC_W + 1;
    localparam int MAN_W = FRAC_W + 1;
    localparam int SUM_W = MAN_W + fpa_pkg::GRS_W + 1;
    localparam int ES_W  = EXP_W + 2;
    localparam int EMAX  = (1 << EXP_W) - 1;
    localparam logic signed [ES_W-1:0] E_LO = '0;
    localparam logic signed [ES_W-1:0] E_HI = ES_W'(EMAX - 1);

    typedef struct packed {
        logic                vld;
        logic [W-1:0]        res;
        fpa_pkg::fpa_flags_t flg;
    } state_t;

    state_t st_d, st_q;

    // ---- unpack both operands ----
    logic [W-1:0]     op_word [2];
    logic [1:0]       u_sign;
    logic [1:0]       u_odd;
    logic [EXP_W-1:0] u_exp   [2];
    logic [MAN_W-1:0] u_man   [2];

    assign op_word[0] = opa;
    assign op_word[1] = opb;

    for (genvar k = 0; k < 2; k++) begin : g_unp
        fpa_unpack #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_unp (
            .word (op_word[k]),
            .flip ((k == 1) ? op_sub : 1'b0),
            .sign (u_sign[k]),
            .expo (u_exp[k]),
            .man  (u_man[k]),
            .odd  (u_odd[k])
        );
    end

    // ---- align and add ----
    logic [SUM_W-1:0] sum;
    logic [EXP_W-1:0] e_big;
    logic             s_big;

    fpa_align_add #(
        .EXP_W (EXP_W),
        .MAN_W (MAN_W)
    ) u_add (
        .sa    (u_sign[0]),
        .ea    (u_exp[0]),
        .ma    (u_man[0]),
        .sb    (u_sign[1]),
        .eb    (u_exp[1]),
        .mb    (u_man[1]),
        .sum   (sum),
        .e_big (e_big),
        .s_big (s_big)
    );

    // ---- normalise ----
    logic [MAN_W-1:0]       n_man;
    logic signed [ES_W-1:0] n_exp;
    logic                   n_grd;
    logic                   n_inx;
    logic                   n_zero;

    fpa_normalize #(
        .EXP_W (EXP_W),
        .MAN_W (MAN_W)
    ) u_norm (
        .sum   (sum),
        .e_big (e_big),
        .man   (n_man),
        .exp_s (n_exp),
        .grd   (n_grd),
        .inx   (n_inx),
        .zero  (n_zero)
    );

    // ---- range policy and flag priority ----
    logic inv_d;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        inv_d    = |u_odd;
        if (in_valid) begin
            st_d.flg     = '0;
            st_d.flg.inv = inv_d;
            if (n_zero) begin
                st_d.res = {u_sign[0], {(W-1){1'b0}}};
            end else if (n_exp <= E_LO) begin
                st_d.res     = {s_big, {(W-1){1'b0}}};
                st_d.flg.unf = !inv_d;
            end else if (n_exp >= E_HI) begin
                st_d.res     = {s_big, E_HI[EXP_W-1:0], {FRAC_W{1'b1}}};
                st_d.flg.ovf = !inv_d;
            end else begin
                st_d.res     = {s_big, n_exp[EXP_W-1:0], n_man[FRAC_W-1:0]};
                st_d.flg.grd = !inv_d && n_grd;
                st_d.flg.inx = !inv_d && n_inx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid      = st_q.vld;
    assign result         = st_q.res;
    assign flag_invalid   = st_q.flg.inv;
    assign flag_overflow  = st_q.flg.ovf;
    assign flag_underflow = st_q.flg.unf;
    assign flag_guard     = st_q.flg.grd;
    assign flag_inexact   = st_q.flg.inx;

endmodule

// File: rtl/fpa_addsub_chk.sv
module fpa_addsub_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [EXP_W+FRAC_W:0] opa,
    input logic                  out_valid,
    input logic [EXP_W+FRAC_W:0] result,
    input logic                  flag_invalid,
    input logic                  flag_overflow,
    input logic                  flag_underflow,
    input logic                  flag_guard,
    input logic                  flag_inexact
);

    localparam int W = EXP_W + FRAC_W + 1;

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid)
        else $error("R1 out_valid missing after accepted input");

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid)
        else $error("R1 out_valid without accepted input");

    a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable({flag_invalid, flag_overflow,
                       flag_underflow, flag_guard, flag_inexact})))
        else $error("R10 result changed while idle");

    a_r4_special_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&opa[W-2 -: EXP_W])) |=> flag_invalid)
        else $error("R4 special operand not flagged invalid");

    a_r5_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flag_underflow |-> (result[W-2:0] == '0))
        else $error("R5 underflow without zero magnitude");

    a_r6_clamp_max: assert property (@(posedge clk) disable iff (!rst_n)
        flag_overflow |-> (result[W-2:0] == {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}}))
        else $error("R6 overflow without max magnitude");

    a_r6_single_range_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({flag_invalid, flag_overflow, flag_underflow}) <= 1)
        else $error("R5/R6 range flags not exclusive");

    a_r9_low_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_invalid || flag_overflow || flag_underflow) |-> !(flag_guard || flag_inexact))
        else $error("R9 guard or inexact raised with a higher flag");

    a_r11_no_special_out: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!(&result[W-2 -: EXP_W]) &&
                       !((~|result[W-2 -: EXP_W]) && (|result[FRAC_W-1:0]))))
        else $error("R11 result is a special encoding");

endmodule

bind fpa_addsub fpa_addsub_chk #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .opa            (opa),
    .out_valid      (out_valid),
    .result         (result),
    .flag_invalid   (flag_invalid),
    .flag_overflow  (flag_overflow),
    .flag_underflow (flag_underflow),
    .flag_guard     (flag_guard),
    .flag_inexact   (flag_inexact)
);

// File: tb/sim_fpa_addsub.sv
`timescale 1ns/1ps
module sim_fpa_addsub;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_invalid, flag_overflow, flag_underflow, flag_guard, flag_inexact;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [36:0] exp_q[$];
    string       tag_q[$];
    logic [36:0] last_exp = '0;

    always #2 clk = ~clk;

    fpa_addsub u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
        .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
        .flag_underflow(flag_underflow), .flag_guard(flag_guard),
        .flag_inexact(flag_inexact)
    );

    // Exact model: every operand becomes an integer scaled by 2^150
    function automatic logic [36:0] ref_model(input logic [31:0] a, input logic [31:0] b,
                                              input logic sub);
        logic [299:0] va, vb, mag;
        logic [299:0] shv;
        logic         sa, sb, sr, inv, ovf, unf, grd, inx, found;
        logic [31:0]  res;
        int           xa, xb, p, be;
        logic [23:0]  ma, mb;
        inv = 1'b0; ovf = 1'b0; unf = 1'b0; grd = 1'b0; inx = 1'b0;
        sa = a[31];
        sb = b[31] ^ sub;
        if (a[30:23] == 8'hFF) begin ma = {1'b1, a[22:0]}; xa = 255; inv = 1'b1; end
        else if (a[30:23] == 8'h00) begin ma = {1'b0, a[22:0]}; xa = 1; if (a[22:0] != 0) inv = 1'b1; end
        else begin ma = {1'b1, a[22:0]}; xa = int'(a[30:23]); end
        if (b[30:23] == 8'hFF) begin mb = {1'b1, b[22:0]}; xb = 255; inv = 1'b1; end
        else if (b[30:23] == 8'h00) begin mb = {1'b0, b[22:0]}; xb = 1; if (b[22:0] != 0) inv = 1'b1; end
        else begin mb = {1'b1, b[22:0]}; xb = int'(b[30:23]); end
        va = 300'(ma) << xa;
        vb = 300'(mb) << xb;
        if (sa == sb) begin mag = va + vb; sr = sa; end
        else if (va > vb) begin mag = va - vb; sr = sa; end
        else if (vb > va) begin mag = vb - va; sr = sb; end
        else begin mag = '0; sr = sa; end
        if (mag == 0) begin
            res = {sa, 31'h0};
        end else begin
            p = 0; found = 1'b0;
            for (int i = 299; i >= 0; i--) begin
                if (!found && mag[i]) begin p = i; found = 1'b1; end
            end
            be = p - 23;
            if (be <= 0) begin
                res = {sr, 31'h0}; unf = !inv;
            end else if (be >= 254) begin
                res = {sr, 31'h7F7FFFFF}; ovf = !inv;
            end else begin
                shv = mag >> (p - 23);
                res = {sr, 8'(be), shv[22:0]};
                if (!inv) begin
                    grd = mag[p-24];
                    shv = mag << (300 - (p - 24));
                    inx = (shv != 0);
                end
            end
        end
        return {res, inv, ovf, unf, grd, inx};
    endfunction

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sub,
                         input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        opa      = a;
        opb      = b;
        op_sub   = sub;
        last_exp = ref_model(a, b, sub);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opa      = $urandom;
            opb      = $urandom;
            op_sub   = 1'(i);
        end
    endtask

    // Monitor: compare each produced result with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            logic [36:0] got;
            logic [36:0] want;
            string       tg;
            got = {result, flag_invalid, flag_overflow, flag_underflow, flag_guard, flag_inexact};
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R1: unexpected output res=%h, expected no output", result);
            end else begin
                want = exp_q.pop_front();
                tg   = tag_q.pop_front();
                if (got !== want) begin
                    failures++;
                    $display("FAIL %s: res=%h flags=%b expected res=%h flags=%b",
                             tg, got[36:5], got[4:0], want[36:5], want[4:0]);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] ra, rb;
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if ({out_valid, result, flag_invalid, flag_overflow, flag_underflow,
             flag_guard, flag_inexact} !== '0) begin
            failures++;
            $display("FAIL R1: reset state %h, expected 0", result);
        end
        rst_n = 1'b1;
        idle(2);

        // R3 plain sums, sign of larger magnitude
        issue(32'h3F800000, 32'h3F800000, 1'b0, "R3");
        issue(32'h40400000, 32'h3F800000, 1'b0, "R3");
        issue(32'hC0400000, 32'h3F800000, 1'b0, "R3");
        // R2 subtraction by sign inversion
        issue(32'h40000000, 32'h3F800000, 1'b1, "R2");
        issue(32'h3F800000, 32'hC0000000, 1'b1, "R2");
        // R7 exact zero takes sign of opa
        issue(32'h3F800000, 32'h3F800000, 1'b1, "R7");
        issue(32'hBF800000, 32'h3F800000, 1'b0, "R7");
        issue(32'h80000000, 32'h00000000, 1'b0, "R7");
        // R8 guard and inexact
        issue(32'h3F800000, 32'h33800000, 1'b0, "R8");
        issue(32'h3F800000, 32'h33C00000, 1'b0, "R8");
        issue(32'h3F800000, 32'h30800000, 1'b0, "R8");
        issue(32'h3F800000, 32'h33800000, 1'b1, "R8");
        issue(32'h3F800000, 32'h2F800001, 1'b1, "R8");
        // R6 clamp at and above biased 254
        issue(32'h7F000000, 32'h7F000000, 1'b0, "R6");
        issue(32'h7F000000, 32'h00000000, 1'b0, "R6");
        issue(32'hFF000000, 32'hFF000000, 1'b0, "R6");
        issue(32'h7E800000, 32'h00000000, 1'b0, "R6");
        // R5 flush at biased 0 and below
        issue(32'h00C00000, 32'h00800000, 1'b1, "R5");
        issue(32'h80C00000, 32'h80800000, 1'b1, "R5");
        issue(32'h00800000, 32'h00000000, 1'b0, "R5");
        // R4 special operands computed as numbers
        issue(32'h7F800000, 32'h3F800000, 1'b0, "R4");
        issue(32'h7FC00000, 32'h7FC00000, 1'b0, "R4");
        issue(32'h7F800000, 32'h7F800000, 1'b1, "R4");
        issue(32'h00400000, 32'h00400000, 1'b0, "R4");
        issue(32'h00000003, 32'h00000001, 1'b1, "R4");
        // R9 lower flags suppressed
        issue(32'h00000001, 32'h3F800000, 1'b0, "R9");
        issue(32'h3F800000, 32'h00700001, 1'b1, "R9");

        // R10 hold while idle, inputs wiggling
        idle(4);
        checks++;
        if ({out_valid, result, flag_invalid, flag_overflow, flag_underflow, flag_guard,
             flag_inexact} !== {1'b0, last_exp}) begin
            failures++;
            $display("FAIL R10: res=%h valid=%b, expected res=%h valid=0",
                     result, out_valid, last_exp[36:5]);
        end

        // R3/R11 random operands, some with nearby exponents
        for (int n = 0; n < 400; n++) begin
            ra = $urandom;
            rb = $urandom;
            if (n % 2 == 0) rb[30:23] = ra[30:23] + 8'($urandom_range(0, 3));
            if (n % 7 == 0) begin
                idle(1);
            end
            issue(ra, rb, 1'($urandom), "R11");
        end
        idle(4);

        // R1 every accepted operation produced exactly one result
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R1: %0d results missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule